// File: doc/BRIEF.md
# Two-Stage DRAM Group Command Scheduler

This unit schedules DRAM commands for one group slice of a DDR4-style memory controller. Read, write and read-modify-write transactions arrive on a valid/ready request port. Each transaction carries a rank, bank group, bank, row and column. They queue in a row-management stage. That stage looks only at its oldest entry and compares the wanted row with a per-bank page table. From this it raises a Precharge request, an Activate request, or hands the transaction to a column stage.

The column stage owns a second queue and raises column (CAS) requests in arrival order. A read-modify-write becomes a read CAS followed by a write CAS. Because the two stages run at the same time, row work for later transactions overlaps the column work of earlier ones.

Per-slot down-counters enforce the activate-to-column, precharge-to-activate and activate-to-precharge spacings. Both request ports wait on a grant from an outside arbiter. A mode input chooses how bank addresses fold onto the four tracked slots per rank.

Top module: `grp_cmd_sched`

## Requirements
- R1: `req_ready` is high after reset and whenever stage 1 holds fewer than DEPTH transactions. It goes low once DEPTH transactions wait in stage 1. After reset no command request is raised.
- R2: When the stage 1 head targets a closed slot, an Activate is requested (`pa_is_act`=1) with the head's rank, bank group, bank and row. After the grant, the slot counts as open on that row.
- R3: A head whose row is already open in its slot moves to stage 2 with no Precharge or Activate.
- R4: A head whose slot is open on another row gets a Precharge (`pa_is_act`=0) and then an Activate of the new row.
- R5: An Activate is raised exactly T_RP cycles after a Precharge grant to its slot, and not earlier. A CAS is raised T_RCD cycles after the Activate grant. A Precharge is raised no sooner than T_RAS cycles after the Activate grant.
- R6: CAS requests leave in the order transactions were accepted.
- R7: For `req_op`=2 (read-modify-write), a read CAS (`cas_write`=0) and then a write CAS (`cas_write`=1) go out to the same column before the next transaction. `req_op`=0 is a read and `req_op`=1 is a write.
- R8: With `req_ap`=1, the final CAS carries `cas_ap`=1 and waits for T_RAS. It closes the slot and starts the T_RP count. A later transaction to the same row is not promoted while that CAS is pending; it needs a new Activate.
- R9: A Precharge is never raised while stage 2 still holds a transaction for that slot.
- R10: With `mode_x16`=0 the slot within a rank is the bank number. With `mode_x16`=1 it is bank bit 1, so bank bit 0 is ignored.
- R11: A raised request keeps its fields unchanged until granted.
- R12: Stage 1 keeps raising Activates for later transactions while a stage 2 CAS waits for its grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_x16 | input | 1 | Bank folding mode, held static |
| req_valid | input | 1 | Transaction offered |
| req_ready | output | 1 | Stage 1 has room |
| req_op | input | 2 | 0 read, 1 write, 2 read-modify-write |
| req_ap | input | 1 | Close the row after the final CAS |
| req_rank | input | RANK_W | Rank |
| req_bg | input | 2 | Bank group |
| req_ba | input | 2 | Bank |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| pa_valid | output | 1 | Precharge/Activate request |
| pa_is_act | output | 1 | 1 Activate, 0 Precharge |
| pa_rank | output | RANK_W | Target rank |
| pa_bg | output | 2 | Target bank group |
| pa_ba | output | 2 | Target bank |
| pa_row | output | ROW_W | Row to open |
| pa_grant | input | 1 | Arbiter accepts the row request |
| cas_valid | output | 1 | Column request |
| cas_write | output | 1 | 1 write, 0 read |
| cas_ap | output | 1 | Auto-precharge with this CAS |
| cas_rank | output | RANK_W | Target rank |
| cas_bg | output | 2 | Target bank group |
| cas_ba | output | 2 | Target bank |
| cas_col | output | COL_W | Column |
| cas_grant | input | 1 | Arbiter accepts the column request |

## Verification
The bench aims at the spacing rules. It measures the exact cycle gap between grants and the next request, so a timer that reloads one short or counts one long shows up as an off-by-one gap.

It holds column grants back with a row conflict queued behind. A design that precharges over a pending CAS would then raise a Precharge early. An auto-precharge followed by a hit on the same row catches a design that promotes the second transaction onto a row that is about to close; such a design shows no second Activate.

Read-modify-write ordering, the x16 fold that merges banks 0 and 1, and requests that are held ungranted complete the set. Together they expose swapped CAS types, a wrong slot index and fields that drift while waiting.

// File: rtl/grp_sched_pkg.sv
package grp_sched_pkg;

  localparam int unsigned SLOTS_PER_RANK = 4;
  localparam int unsigned BG_W = 2;
  localparam int unsigned BA_W = 2;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_RMW = 2'd2,
    OP_RSV = 2'd3
  } op_e;

  // Slot inside the page/timer tables for a rank and bank in a given mode.
  function automatic int unsigned bank_slot(input logic x16, input logic [1:0] ba,
                                            input int unsigned rank);
    return (rank << 2) + 32'(x16 ? {1'b0, ba[1]} : ba);
  endfunction

  // Counter value loaded on a grant so that the next command sees zero
  // exactly t cycles after the granting cycle.
  function automatic int unsigned timer_load(input int unsigned t);
    return (t == 0) ? 0 : t - 1;
  endfunction

endpackage

// File: rtl/grp_fifo.sv
module grp_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign rdata = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);

endmodule

// File: rtl/grp_bank_timers.sv
module grp_bank_timers #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RCD = 4,
  parameter int unsigned T_RAS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] act_hit,
  input  logic [SLOTS-1:0] pre_hit,
  input  logic [SLOTS-1:0] cas_hit,
  output logic [SLOTS-1:0] rp_ok,
  output logic [SLOTS-1:0] rcd_ok,
  output logic [SLOTS-1:0] ras_ok
);
  import grp_sched_pkg::*;

  localparam int unsigned T_MAX = (T_RAS > T_RCD) ? ((T_RAS > T_RP) ? T_RAS : T_RP)
                                                  : ((T_RCD > T_RP) ? T_RCD : T_RP);
  localparam int unsigned CW = $clog2(T_MAX + 1);
  localparam logic [CW-1:0] LD_RP  = CW'(timer_load(T_RP));
  localparam logic [CW-1:0] LD_RCD = CW'(timer_load(T_RCD));
  localparam logic [CW-1:0] LD_RAS = CW'(timer_load(T_RAS));

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [CW-1:0] rp_cnt, rcd_cnt, ras_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rp_cnt  <= '0;
        rcd_cnt <= '0;
        ras_cnt <= '0;
      end else begin
        if (pre_hit[s])         rp_cnt <= LD_RP;
        else if (rp_cnt != '0)  rp_cnt <= rp_cnt - 1'b1;
        if (act_hit[s])         rcd_cnt <= LD_RCD;
        else if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
        if (act_hit[s])         ras_cnt <= LD_RAS;
        else if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
      end
    end

    assign rp_ok[s]  = (rp_cnt == '0);
    assign rcd_ok[s] = (rcd_cnt == '0);
    assign ras_ok[s] = (ras_cnt == '0);

    a_r5_act_after_rp: assert property (@(posedge clk) disable iff (!rst_n)
      act_hit[s] |-> rp_cnt == '0);
    a_r5_cas_after_rcd: assert property (@(posedge clk) disable iff (!rst_n)
      cas_hit[s] |-> rcd_cnt == '0);
    a_r5_pre_after_ras: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_hit[s] && !act_hit[s]) |-> ras_cnt == '0);
  end

endmodule

// File: rtl/grp_page_table.sv
module grp_page_table #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned ROW_W = 14,
  parameter int unsigned DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SLOTS-1:0]            act_set,
  input  logic [ROW_W-1:0]            act_row,
  input  logic [SLOTS-1:0]            pre_cmd,
  input  logic [SLOTS-1:0]            ap_close,
  input  logic [SLOTS-1:0]            pend_inc,
  input  logic [SLOTS-1:0]            pend_dec,
  input  logic [SLOTS-1:0]            apc_inc,
  output logic [SLOTS-1:0]            open_q,
  output logic [SLOTS-1:0][ROW_W-1:0] row_q,
  output logic [SLOTS-1:0]            idle,
  output logic [SLOTS-1:0]            closing
);
  localparam int unsigned PW = $clog2(DEPTH + 1);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [PW-1:0] pend, apc;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[s] <= 1'b0;
        row_q[s]  <= '0;
        pend      <= '0;
        apc       <= '0;
      end else begin
        if (act_set[s]) begin
          open_q[s] <= 1'b1;
          row_q[s]  <= act_row;
        end else if (pre_cmd[s] || ap_close[s]) begin
          open_q[s] <= 1'b0;
        end
        pend <= pend + PW'(pend_inc[s]) - PW'(pend_dec[s]);
        apc  <= apc + PW'(apc_inc[s]) - PW'(ap_close[s]);
      end
    end

    assign idle[s]    = (pend == '0);
    assign closing[s] = (apc != '0);

    a_r2_act_closed: assert property (@(posedge clk) disable iff (!rst_n)
      act_set[s] |-> !open_q[s]);
    a_r9_pre_idle: assert property (@(posedge clk) disable iff (!rst_n)
      pre_cmd[s] |-> pend == '0);
    a_r6_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
      pend_inc[s] |-> pend != PW'(DEPTH));
  end

endmodule

// File: rtl/grp_cas_ctl.sv
module grp_cas_ctl
  import grp_sched_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic head_valid,
  input  op_e  head_op,
  input  logic head_ap,
  input  logic rcd_ok,
  input  logic ras_ok,
  input  logic cas_grant,
  output logic cas_valid,
  output logic cas_write,
  output logic cas_ap,
  output logic cas_done
);
  logic rmw_wr_q;
  logic is_rmw, last_cas, granted;

  assign is_rmw    = (head_op == OP_RMW);
  assign last_cas  = !is_rmw || rmw_wr_q;
  assign cas_write = (head_op == OP_WR) || (is_rmw && rmw_wr_q);
  assign cas_ap    = head_ap && last_cas;
  assign cas_valid = head_valid && rcd_ok && (!cas_ap || ras_ok);
  assign granted   = cas_valid && cas_grant;
  assign cas_done  = granted && last_cas;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             rmw_wr_q <= 1'b0;
    else if (granted && is_rmw && !rmw_wr_q) rmw_wr_q <= 1'b1;
    else if (cas_done)                      rmw_wr_q <= 1'b0;
  end

  a_r11_cas_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_valid && !cas_grant) |=> cas_valid && $stable(cas_write) && $stable(cas_ap));
  a_r7_rmw_write_next: assert property (@(posedge clk) disable iff (!rst_n)
    (granted && is_rmw && !cas_write) |=> head_valid && cas_write);

endmodule

// File: rtl/grp_cmd_sched.sv
module grp_cmd_sched
  import grp_sched_pkg::*;
#(
  parameter int unsigned RANK_W = 1,
  parameter int unsigned ROW_W  = 14,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned T_RP   = 3,
  parameter int unsigned T_RCD  = 4,
  parameter int unsigned T_RAS  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_x16,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_ap,
  input  logic [RANK_W-1:0] req_rank,
  input  logic [1:0]        req_bg,
  input  logic [1:0]        req_ba,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              pa_valid,
  output logic              pa_is_act,
  output logic [RANK_W-1:0] pa_rank,
  output logic [1:0]        pa_bg,
  output logic [1:0]        pa_ba,
  output logic [ROW_W-1:0]  pa_row,
  input  logic              pa_grant,
  output logic              cas_valid,
  output logic              cas_write,
  output logic              cas_ap,
  output logic [RANK_W-1:0] cas_rank,
  output logic [1:0]        cas_bg,
  output logic [1:0]        cas_ba,
  output logic [COL_W-1:0]  cas_col,
  input  logic              cas_grant
);
  localparam int unsigned RANKS  = 1 << RANK_W;
  localparam int unsigned SLOTS  = RANKS * SLOTS_PER_RANK;
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  typedef struct packed {
    op_e               op;
    logic              ap;
    logic [RANK_W-1:0] rank;
    logic [1:0]        bg;
    logic [1:0]        ba;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } txn_t;

  txn_t req_txn, h1, h2;
  logic s1_push, s1_pop, s1_empty, s1_full;
  logic s2_empty, s2_full;
  logic [SLOT_W-1:0] s1_slot, s2_slot;
  logic s1_hit, s1_xfer, pre_req, act_req, cas_done;

  logic [SLOTS-1:0] open_q, idle, closing, rp_ok, rcd_ok, ras_ok;
  logic [SLOTS-1:0][ROW_W-1:0] row_q;
  logic [SLOTS-1:0] act_vec, pre_vec, apc_vec, xfer_vec, xap_vec, done_vec, cas_vec;

  function automatic logic [SLOTS-1:0] slot_bit(input logic go, input logic [SLOT_W-1:0] s);
    return go ? (SLOTS'(1) << s) : '0;
  endfunction

  // Request intake into stage 1
  assign req_txn   = '{op: op_e'(req_op), ap: req_ap, rank: req_rank, bg: req_bg,
                       ba: req_ba, row: req_row, col: req_col};
  assign req_ready = !s1_full;
  assign s1_push   = req_valid && req_ready;

  grp_fifo #(.DEPTH(DEPTH), .WIDTH($bits(txn_t))) u_s1_fifo (
    .clk(clk), .rst_n(rst_n), .push(s1_push), .wdata(req_txn), .pop(s1_pop),
    .rdata(h1), .empty(s1_empty), .full(s1_full));

  // Stage 1: row management on the head transaction
  assign s1_slot = SLOT_W'(bank_slot(mode_x16, h1.ba, 32'(h1.rank)));
  assign s1_hit  = open_q[s1_slot] && (row_q[s1_slot] == h1.row);

  always_comb begin
    s1_xfer = 1'b0;
    pre_req = 1'b0;
    act_req = 1'b0;
    if (!s1_empty) begin
      if (s1_hit)               s1_xfer = !closing[s1_slot] && !s2_full;
      else if (open_q[s1_slot]) pre_req = ras_ok[s1_slot] && idle[s1_slot];
      else                      act_req = rp_ok[s1_slot] && !closing[s1_slot];
    end
  end

  assign s1_pop    = s1_xfer;
  assign pa_valid  = pre_req || act_req;
  assign pa_is_act = act_req;
  assign pa_rank   = h1.rank;
  assign pa_bg     = h1.bg;
  assign pa_ba     = h1.ba;
  assign pa_row    = h1.row;

  // Stage 2: column issue in order
  grp_fifo #(.DEPTH(DEPTH), .WIDTH($bits(txn_t))) u_s2_fifo (
    .clk(clk), .rst_n(rst_n), .push(s1_xfer), .wdata(h1), .pop(cas_done),
    .rdata(h2), .empty(s2_empty), .full(s2_full));

  assign s2_slot = SLOT_W'(bank_slot(mode_x16, h2.ba, 32'(h2.rank)));

  grp_cas_ctl u_cas (
    .clk(clk), .rst_n(rst_n), .head_valid(!s2_empty), .head_op(h2.op), .head_ap(h2.ap),
    .rcd_ok(rcd_ok[s2_slot]), .ras_ok(ras_ok[s2_slot]), .cas_grant(cas_grant),
    .cas_valid(cas_valid), .cas_write(cas_write), .cas_ap(cas_ap), .cas_done(cas_done));

  assign cas_rank = h2.rank;
  assign cas_bg   = h2.bg;
  assign cas_ba   = h2.ba;
  assign cas_col  = h2.col;

  // Granted events as per-slot vectors
  assign act_vec  = slot_bit(act_req && pa_grant, s1_slot);
  assign pre_vec  = slot_bit(pre_req && pa_grant, s1_slot);
  assign xfer_vec = slot_bit(s1_xfer, s1_slot);
  assign xap_vec  = slot_bit(s1_xfer && h1.ap, s1_slot);
  assign done_vec = slot_bit(cas_done, s2_slot);
  assign apc_vec  = slot_bit(cas_done && h2.ap, s2_slot);
  assign cas_vec  = slot_bit(cas_valid && cas_grant, s2_slot);

  grp_page_table #(.SLOTS(SLOTS), .ROW_W(ROW_W), .DEPTH(DEPTH)) u_pages (
    .clk(clk), .rst_n(rst_n), .act_set(act_vec), .act_row(h1.row), .pre_cmd(pre_vec),
    .ap_close(apc_vec), .pend_inc(xfer_vec), .pend_dec(done_vec), .apc_inc(xap_vec),
    .open_q(open_q), .row_q(row_q), .idle(idle), .closing(closing));

  grp_bank_timers #(.SLOTS(SLOTS), .T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS)) u_timers (
    .clk(clk), .rst_n(rst_n), .act_hit(act_vec), .pre_hit(pre_vec | apc_vec),
    .cas_hit(cas_vec), .rp_ok(rp_ok), .rcd_ok(rcd_ok), .ras_ok(ras_ok));

  a_r3_cas_page_open: assert property (@(posedge clk) disable iff (!rst_n)
    cas_valid |-> open_q[s2_slot] && (row_q[s2_slot] == h2.row));
  a_r11_pa_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_valid && !pa_grant) |=> pa_valid &&
      $stable({pa_is_act, pa_rank, pa_bg, pa_ba, pa_row}));

endmodule

// File: tb/grp_cmd_sched_tb.sv
module grp_cmd_sched_tb;
  localparam int T_RP = 3, T_RCD = 4, T_RAS = 9;

  logic clk = 0, rst_n = 0, mode_x16 = 0;
  logic req_valid = 0, req_ap = 0;
  logic [1:0] req_op = 0, req_bg = 0, req_ba = 0;
  logic [0:0] req_rank = 0;
  logic [13:0] req_row = 0;
  logic [9:0] req_col = 0;
  logic req_ready, pa_valid, pa_is_act, cas_valid, cas_write, cas_ap;
  logic [0:0] pa_rank, cas_rank;
  logic [1:0] pa_bg, pa_ba, cas_bg, cas_ba;
  logic [13:0] pa_row;
  logic [9:0] cas_col;
  logic pa_grant = 0, cas_grant = 0;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit pa_auto = 0, cas_auto = 0, done = 0;
  int pa_n, cas_n;
  bit pa_act_l[64], cas_wr_l[64], cas_ap_l[64];
  int pa_row_l[64], pa_cyc_l[64], cas_col_l[64], cas_cyc_l[64];

  grp_cmd_sched u_dut (
    .clk(clk), .rst_n(rst_n), .mode_x16(mode_x16), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_ap(req_ap), .req_rank(req_rank),
    .req_bg(req_bg), .req_ba(req_ba), .req_row(req_row), .req_col(req_col),
    .pa_valid(pa_valid), .pa_is_act(pa_is_act), .pa_rank(pa_rank), .pa_bg(pa_bg),
    .pa_ba(pa_ba), .pa_row(pa_row), .pa_grant(pa_grant), .cas_valid(cas_valid),
    .cas_write(cas_write), .cas_ap(cas_ap), .cas_rank(cas_rank), .cas_bg(cas_bg),
    .cas_ba(cas_ba), .cas_col(cas_col), .cas_grant(cas_grant));

  initial forever #5 clk = ~clk;

  // Arbiter model and grant log, driven at the falling edge
  initial forever begin
    @(negedge clk);
    cyc++;
    pa_grant = pa_auto && pa_valid;
    if (pa_grant && pa_n < 64) begin
      pa_act_l[pa_n] = pa_is_act; pa_row_l[pa_n] = int'(pa_row); pa_cyc_l[pa_n] = cyc;
      pa_n++;
    end
    cas_grant = cas_auto && cas_valid;
    if (cas_grant && cas_n < 64) begin
      cas_wr_l[cas_n] = cas_write; cas_ap_l[cas_n] = cas_ap;
      cas_col_l[cas_n] = int'(cas_col); cas_cyc_l[cas_n] = cyc;
      cas_n++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit x16);
    @(negedge clk);
    pa_auto = 0; cas_auto = 0; rst_n = 0; mode_x16 = x16;
    repeat (3) @(negedge clk);
    pa_n = 0; cas_n = 0;
    rst_n = 1;
  endtask

  task automatic push(input int op, input bit ap, input int ba, input int row, input int col);
    @(negedge clk);
    req_op = 2'(op); req_ap = ap; req_rank = 0; req_bg = 2'd1; req_ba = 2'(ba);
    req_row = 14'(row); req_col = 10'(col); req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic idle_for(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(0);
    #1;
    check("R1 ready after reset", int'(req_ready), 1);
    check("R1 no row request after reset", int'(pa_valid), 0);
    check("R1 no cas request after reset", int'(cas_valid), 0);
  endtask

  task automatic t_fill;
    do_reset(0);
    for (int i = 0; i < 4; i++) push(0, 0, i, 10 + i, 1 + i);
    @(negedge clk); #1;
    check("R1 ready low when stage 1 full", int'(req_ready), 0);
    check("R2 activate raised", int'(pa_valid && pa_is_act), 1);
    check("R2 activate row", int'(pa_row), 10);
    check("R2 activate bank", int'(pa_ba), 0);
    idle_for(5); #1;
    check("R11 row request held", int'(pa_valid && pa_is_act && pa_row == 10), 1);
    pa_auto = 1; cas_auto = 1;
    idle_for(80);
    check("R2 one activate per bank", pa_n, 4);
    check("R6 cas count", cas_n, 4);
    for (int i = 0; i < 4; i++) check("R6 cas order", cas_col_l[i], 1 + i);
    check("R5 activate to cas spacing", cas_cyc_l[0] - pa_cyc_l[0], T_RCD);
  endtask

  task automatic t_conflict;
    do_reset(0);
    pa_auto = 1; cas_auto = 1;
    push(0, 0, 0, 5, 7);
    push(1, 0, 0, 9, 8);
    push(0, 0, 0, 9, 9);
    idle_for(80);
    check("R3 no row command for page hit", pa_n, 3);
    check("R4 precharge on conflict", int'(pa_act_l[1]), 0);
    check("R4 activate new row", pa_row_l[2], 9);
    check("R5 activate to precharge spacing", pa_cyc_l[1] - pa_cyc_l[0], T_RAS);
    check("R5 precharge to activate spacing", pa_cyc_l[2] - pa_cyc_l[1], T_RP);
    check("R6 cas count conflict", cas_n, 3);
    check("R7 write type on write op", int'(cas_wr_l[1]), 1);
    check("R6 last cas column", cas_col_l[2], 9);
  endtask

  task automatic t_prewait;
    do_reset(0);
    pa_auto = 1;
    push(0, 0, 1, 1, 1);
    push(0, 0, 1, 2, 2);
    idle_for(30);
    check("R9 no precharge with pending cas", pa_n, 1);
    check("R9 cas waiting", int'(cas_valid), 1);
    cas_auto = 1;
    idle_for(40);
    check("R9 precharge after cas", int'(pa_n == 3 && !pa_act_l[1]), 1);
    check("R9 precharge one cycle after cas grant", pa_cyc_l[1] - cas_cyc_l[0], 1);
  endtask

  task automatic t_rmw;
    do_reset(0);
    pa_auto = 1; cas_auto = 1;
    push(2, 0, 2, 4, 'h33);
    push(0, 0, 2, 4, 'h34);
    idle_for(40);
    check("R7 cas count rmw", cas_n, 3);
    check("R7 first is read", int'(cas_wr_l[0]), 0);
    check("R7 second is write", int'(cas_wr_l[1]), 1);
    check("R7 same column", cas_col_l[1], 'h33);
    check("R7 next txn after pair", cas_col_l[2], 'h34);
  endtask

  task automatic t_ap;
    do_reset(0);
    pa_auto = 1; cas_auto = 1;
    push(0, 1, 3, 7, 5);
    push(0, 0, 3, 7, 6);
    idle_for(80);
    check("R8 reactivate without precharge", int'(pa_n == 2 && pa_act_l[1]), 1);
    check("R8 ap flag on cas", int'(cas_ap_l[0]), 1);
    check("R8 ap cas waits tRAS", cas_cyc_l[0] - pa_cyc_l[0], T_RAS);
    check("R8 activate tRP after ap cas", pa_cyc_l[1] - cas_cyc_l[0], T_RP);
    check("R8 second cas no ap", int'(cas_n == 2 && !cas_ap_l[1] && cas_col_l[1] == 6), 1);
  endtask

  task automatic t_overlap;
    do_reset(0);
    pa_auto = 1;
    push(0, 0, 0, 3, 1);
    push(0, 0, 1, 3, 2);
    idle_for(30);
    check("R12 both activates while cas held", pa_n, 2);
    check("R12 oldest cas waiting", int'(cas_valid && cas_col == 1), 1);
    cas_auto = 1;
    idle_for(30);
    check("R12 both cas issued", cas_n, 2);
  endtask

  task automatic t_mode;
    do_reset(1);
    pa_auto = 1; cas_auto = 1;
    push(0, 0, 0, 3, 1);
    push(0, 0, 1, 3, 2);
    idle_for(40);
    check("R10 x16 folds bank bit 0", pa_n, 1);
    check("R10 x16 cas count", cas_n, 2);
    do_reset(0);
    pa_auto = 1; cas_auto = 1;
    push(0, 0, 0, 3, 1);
    push(0, 0, 1, 3, 2);
    idle_for(40);
    check("R10 x8 banks distinct", pa_n, 2);
  endtask

  initial begin
    t_reset;
    t_fill;
    t_conflict;
    t_prewait;
    t_rmw;
    t_ap;
    t_overlap;
    t_mode;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule